// File: doc/BRIEF.md
# Interrupt Pin Dispatch Engine

This block sits between a set of interrupt input lines and a local interrupt controller. It keeps one pending bit per routed pin. It looks up each pin's redirection entry, which a separate register block supplies. Pins that are eligible go out one at a time as delivery requests under a valid/ready handshake. Each request carries a destination, a destination addressing mode, a delivery mode, a vector and a trigger flag.

Each pin can be configured separately. A pin can be edge or level sensitive and active high or active low, and it can be masked. Level-sensitive pins use a remote-IRR handshake. Once a level request is accepted, that pin goes quiet until an end-of-interrupt broadcast with a matching vector arrives. After that, a pin that is still active is delivered again. In the external-interrupt delivery mode the vector does not come from the entry. The engine fetches it from a legacy controller through a request/acknowledge handshake. Legacy line 0 is steered onto pin 2.

Top module: `pin_dispatch`

## Requirements
- R1: After reset, req_valid and leg_req are low and every remote_irr bit is clear.
- R2: Each pin's entry is ENTRY_W=23 bits at cfg_entries[p*23 +: 23]. Its fields are vector [7:0], delivery mode [10:8], logical-destination flag [11], active-low flag [12], level-trigger flag [13], mask [14] and destination [22:15]. A request copies these fields from the entry of the pin it reports on req_pin.
- R3: On an unmasked edge pin, a rising edge of the corrected level produces exactly one request. Acceptance clears the pin's pending state.
- R4: An edge that arrives while the pin is masked is discarded. Unmasking the pin later produces no request.
- R5: When the active-low flag is set, the input is inverted before edge or level detection, so a falling raw edge is what triggers.
- R6: An accepted level request sets that pin's remote_irr bit. While the bit is set, the pin issues no further request.
- R7: An end-of-interrupt clears remote_irr on every pin whose remote bit is set and whose entry vector equals eoi_vector. If such a pin is still active and unmasked, it is delivered again. A broadcast with any other vector has no effect.
- R8: The pending state of a level pin follows its corrected input. A level pin that has gone inactive before its end-of-interrupt is not delivered again.
- R9: When several pins are eligible, the lowest-numbered pin is delivered first.
- R10: For delivery mode 3'b111, leg_req stays high until leg_ack. No request is presented during that time, and the request then carries leg_vector as its vector.
- R11: While req_valid is high and req_ready is low, req_valid and every request field stay unchanged.
- R12: irq_in[0] and irq_in[2] both drive pin 2, and pin 0 has no source. Every other irq_in[k] drives pin k.
- R13: A level pin that becomes active while masked is delivered once its mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | NPINS | Raw interrupt lines, legacy numbering |
| cfg_entries | input | NPINS*23 | Redirection entries, one per pin |
| req_valid | output | 1 | Delivery request present |
| req_ready | input | 1 | Local controller accepts request |
| req_pin | output | IDX_W | Pin being delivered |
| req_dest | output | 8 | Destination |
| req_dest_logical | output | 1 | Destination addressing mode |
| req_deliv | output | 3 | Delivery mode |
| req_vector | output | 8 | Vector |
| req_level | output | 1 | Level-triggered request |
| leg_req | output | 1 | Vector fetch from legacy controller |
| leg_ack | input | 1 | Legacy vector available |
| leg_vector | input | 8 | Vector from legacy controller |
| eoi_valid | input | 1 | End-of-interrupt broadcast |
| eoi_vector | input | 8 | Vector of the broadcast |
| remote_irr | output | NPINS | Remote-IRR state per pin |

## Verification
The hardest case to reach is redelivery after an end-of-interrupt. It needs a level pin that is held active across an accepted request, a non-matching broadcast that must change nothing, and then a matching broadcast. The bench holds the line high and issues both broadcasts at chosen cycles. It then repeats the sequence with the line dropped first, which shows that the pending state follows the level. The masked-edge case is reached the same way: the entry stays masked while the line toggles, and is unmasked only after the line has settled.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int ENTRY_W = 23;
    localparam logic [2:0] DM_LEGACY = 3'b111;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig_level;
        logic       active_low;
        logic       dest_logical;
        logic [2:0] deliv;
        logic [7:0] vector;
    } pd_entry_t;

    typedef struct packed {
        logic [7:0] dest;
        logic       dest_logical;
        logic [2:0] deliv;
        logic [7:0] vector;
    } pd_payload_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEG  = 2'd1,
        ST_SEND = 2'd2
    } pd_state_e;

endpackage

// File: rtl/pd_irq_route.sv
module pd_irq_route #(
    parameter int NPINS = 24
) (
    input  logic [NPINS-1:0] irq_in,
    output logic [NPINS-1:0] pin_lvl
);
    generate
        if (NPINS < 3) begin : g_bad
            initial $error("pd_irq_route needs at least 3 pins");
        end
    endgenerate

    always_comb begin
        pin_lvl = irq_in;
        pin_lvl[0] = 1'b0;
        pin_lvl[2] = irq_in[0] | irq_in[2];
    end
endmodule

// File: rtl/pd_pin_track.sv
module pd_pin_track #(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] active_low,
    input  logic [NPINS-1:0] trig_level,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] clr_edge,
    output logic [NPINS-1:0] pending
);
    typedef struct packed {
        logic [NPINS-1:0] pend;
        logic [NPINS-1:0] raw_prev;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        trk_d.raw_prev = pin_lvl;
        for (int i = 0; i < NPINS; i++) begin
            logic now_c, prev_c;
            now_c  = pin_lvl[i] ^ active_low[i];
            prev_c = trk_q.raw_prev[i] ^ active_low[i];
            if (trig_level[i]) begin
                trk_d.pend[i] = now_c;
            end else begin
                trk_d.pend[i] = (trk_q.pend[i] & ~clr_edge[i])
                              | (now_c & ~prev_c & ~mask[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pending = trk_q.pend;
endmodule

// File: rtl/pd_lowest_pick.sv
module pd_lowest_pick #(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input  logic [NPINS-1:0] cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pd_issue.sv
module pd_issue
    import pd_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pd_payload_t      pay [NPINS],
    input  logic [NPINS-1:0] trig_level,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] pending,
    output logic [NPINS-1:0] eligible,
    input  logic             found,
    input  logic [IDX_W-1:0] pick,
    output logic [NPINS-1:0] clr_edge,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [IDX_W-1:0] req_pin,
    output pd_payload_t      req_pay,
    output logic             req_level,
    output logic             leg_req,
    input  logic             leg_ack,
    input  logic [7:0]       leg_vector,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vector,
    output logic [NPINS-1:0] remote_irr
);
    typedef struct packed {
        pd_state_e        st;
        logic [IDX_W-1:0] pin;
        pd_payload_t      pay;
        logic             level;
        logic [NPINS-1:0] rirr;
    } iss_t;

    iss_t iss_d, iss_q;
    logic commit;

    assign eligible = pending & ~mask & ~(trig_level & iss_q.rirr);

    always_comb begin
        iss_d    = iss_q;
        commit   = 1'b0;
        clr_edge = '0;

        unique case (iss_q.st)
            ST_IDLE: begin
                if (found) begin
                    iss_d.pin   = pick;
                    iss_d.pay   = pay[pick];
                    iss_d.level = trig_level[pick];
                    iss_d.st    = (pay[pick].deliv == DM_LEGACY) ? ST_LEG : ST_SEND;
                end
            end
            ST_LEG: begin
                if (leg_ack) begin
                    iss_d.pay.vector = leg_vector;
                    iss_d.st         = ST_SEND;
                end
            end
            ST_SEND: begin
                if (req_ready) begin
                    commit   = 1'b1;
                    iss_d.st = ST_IDLE;
                end
            end
            default: iss_d.st = ST_IDLE;
        endcase

        for (int i = 0; i < NPINS; i++) begin
            if (eoi_valid && iss_q.rirr[i] && pay[i].vector == eoi_vector) begin
                iss_d.rirr[i] = 1'b0;
            end
            if (commit && iss_q.pin == IDX_W'(i)) begin
                if (iss_q.level) begin
                    iss_d.rirr[i] = 1'b1;
                end else begin
                    clr_edge[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_q    <= '0;
            iss_q.st <= ST_IDLE;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign req_valid  = (iss_q.st == ST_SEND);
    assign leg_req    = (iss_q.st == ST_LEG);
    assign req_pin    = iss_q.pin;
    assign req_pay    = iss_q.pay;
    assign req_level  = iss_q.level;
    assign remote_irr = iss_q.rirr;
endmodule

// File: rtl/pin_dispatch.sv
module pin_dispatch
    import pd_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPINS-1:0]         irq_in,
    input  logic [NPINS*ENTRY_W-1:0] cfg_entries,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [IDX_W-1:0]         req_pin,
    output logic [7:0]               req_dest,
    output logic                     req_dest_logical,
    output logic [2:0]               req_deliv,
    output logic [7:0]               req_vector,
    output logic                     req_level,
    output logic                     leg_req,
    input  logic                     leg_ack,
    input  logic [7:0]               leg_vector,
    input  logic                     eoi_valid,
    input  logic [7:0]               eoi_vector,
    output logic [NPINS-1:0]         remote_irr
);
    pd_entry_t        ent [NPINS];
    pd_payload_t      pay [NPINS];
    logic [NPINS-1:0] active_low, trig_level, mask;
    logic [NPINS-1:0] pin_lvl, pending, eligible, clr_edge;
    logic             found;
    logic [IDX_W-1:0] pick;
    pd_payload_t      req_pay;

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_unpack
            assign ent[g]        = pd_entry_t'(cfg_entries[g*ENTRY_W +: ENTRY_W]);
            assign active_low[g] = ent[g].active_low;
            assign trig_level[g] = ent[g].trig_level;
            assign mask[g]       = ent[g].mask;
            assign pay[g]        = '{dest: ent[g].dest, dest_logical: ent[g].dest_logical,
                                     deliv: ent[g].deliv, vector: ent[g].vector};
        end
    endgenerate

    pd_irq_route #(.NPINS(NPINS)) u_route (
        .irq_in  (irq_in),
        .pin_lvl (pin_lvl)
    );

    pd_pin_track #(.NPINS(NPINS)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_lvl    (pin_lvl),
        .active_low (active_low),
        .trig_level (trig_level),
        .mask       (mask),
        .clr_edge   (clr_edge),
        .pending    (pending)
    );

    pd_lowest_pick #(.NPINS(NPINS), .IDX_W(IDX_W)) u_pick (
        .cand  (eligible),
        .found (found),
        .idx   (pick)
    );

    pd_issue #(.NPINS(NPINS), .IDX_W(IDX_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .pay        (pay),
        .trig_level (trig_level),
        .mask       (mask),
        .pending    (pending),
        .eligible   (eligible),
        .found      (found),
        .pick       (pick),
        .clr_edge   (clr_edge),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_pin    (req_pin),
        .req_pay    (req_pay),
        .req_level  (req_level),
        .leg_req    (leg_req),
        .leg_ack    (leg_ack),
        .leg_vector (leg_vector),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .remote_irr (remote_irr)
    );

    assign req_dest         = req_pay.dest;
    assign req_dest_logical = req_pay.dest_logical;
    assign req_deliv        = req_pay.deliv;
    assign req_vector       = req_pay.vector;
endmodule

// File: rtl/pin_dispatch_chk.sv
module pin_dispatch_chk #(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [IDX_W-1:0] req_pin,
    input logic [7:0]       req_dest,
    input logic             req_dest_logical,
    input logic [2:0]       req_deliv,
    input logic [7:0]       req_vector,
    input logic             req_level,
    input logic             leg_req,
    input logic             leg_ack,
    input logic             eoi_valid,
    input logic [NPINS-1:0] remote_irr
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_pin) && $stable(req_dest)
            && $stable(req_dest_logical) && $stable(req_deliv)
            && $stable(req_vector) && $stable(req_level)));

    // R10
    leg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_req && !leg_ack) |=> leg_req);

    // R10
    leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg_req && req_valid));

    // R6
    rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((remote_irr & ~$past(remote_irr)) != '0) |->
            $past(req_valid && req_ready && req_level));

    // R7
    rirr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(remote_irr) & ~remote_irr) != '0) |-> $past(eoi_valid));

    // R6
    rirr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(remote_irr & ~$past(remote_irr)) <= 1);
endmodule

bind pin_dispatch pin_dispatch_chk #(.NPINS(NPINS), .IDX_W(IDX_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_pin          (req_pin),
    .req_dest         (req_dest),
    .req_dest_logical (req_dest_logical),
    .req_deliv        (req_deliv),
    .req_vector       (req_vector),
    .req_level        (req_level),
    .leg_req          (leg_req),
    .leg_ack          (leg_ack),
    .eoi_valid        (eoi_valid),
    .remote_irr       (remote_irr)
);

// File: tb/pin_dispatch_bench.sv
module pin_dispatch_bench;
    localparam int NP = 8;
    localparam int EW = 23;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] irq_in = '0;
    logic [EW-1:0] ent [NP];
    logic [NP*EW-1:0] cfg;
    logic req_valid, req_ready = 1'b0;
    logic [IW-1:0] req_pin;
    logic [7:0] req_dest, req_vector;
    logic req_dest_logical, req_level, leg_req;
    logic [2:0] req_deliv;
    logic leg_ack = 1'b0;
    logic [7:0] leg_vector = '0;
    logic eoi_valid = 1'b0;
    logic [7:0] eoi_vector = '0;
    logic [NP-1:0] remote_irr;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) cfg[i*EW +: EW] = ent[i];
    end

    pin_dispatch #(.NPINS(NP)) u_pin_dispatch (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_entries(cfg),
        .req_valid(req_valid), .req_ready(req_ready), .req_pin(req_pin),
        .req_dest(req_dest), .req_dest_logical(req_dest_logical),
        .req_deliv(req_deliv), .req_vector(req_vector), .req_level(req_level),
        .leg_req(leg_req), .leg_ack(leg_ack), .leg_vector(leg_vector),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .remote_irr(remote_irr)
    );

    function automatic logic [EW-1:0] mk(input logic [7:0] vec, input logic [2:0] dm,
                                         input logic dl, input logic pol, input logic lvl,
                                         input logic msk, input logic [7:0] dst);
        return {dst, msk, lvl, pol, dl, dm, vec};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        for (int i = 0; i < NP; i++) ent[i] = mk(8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        irq_in = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Wait for a request, optionally hold it unaccepted, compare fields, accept.
    task automatic expect_req(input int pin, input logic [7:0] vec, input logic [7:0] dst,
                              input logic dl, input logic [2:0] dm, input logic lvl,
                              input int hold, input string tag);
        int waited = 0;
        logic [22:0] first;
        while (!req_valid && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check(req_valid, {tag, " request present"}, 64'(req_valid), 64'd1);
        if (req_valid) begin
            first = {req_pin[2:0], req_vector, req_dest, req_dest_logical, req_deliv[0]};
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                // R11
                check(req_valid && first == {req_pin[2:0], req_vector, req_dest,
                      req_dest_logical, req_deliv[0]}, "R11 held request stable",
                      64'({req_valid, req_pin, req_vector, req_dest}), 64'({1'b1, first}));
            end
            check({req_pin, req_vector, req_dest, req_dest_logical, req_deliv, req_level}
                  == {IW'(pin), vec, dst, dl, dm, lvl}, tag,
                  64'({req_pin, req_vector, req_dest, req_dest_logical, req_deliv, req_level}),
                  64'({IW'(pin), vec, dst, dl, dm, lvl}));
            req_ready = 1'b1;
            @(posedge clk);
            #1 req_ready = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic expect_none(input int n, input string tag);
        bit seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (req_valid || leg_req) seen = 1;
        end
        check(!seen, tag, 64'(seen), 64'd0);
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_vector = v;
        eoi_valid = 1'b1;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        #(5ns * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        do_reset();
        // R1
        check(!req_valid && !leg_req && remote_irr == '0, "R1 reset state",
              64'({req_valid, leg_req, remote_irr}), 64'd0);

        // R2 R3: sweep every routed pin with distinct fields
        for (int p = 1; p < NP; p++) begin
            ent[p] = mk(8'h40 + 8'(p), 3'(p % 4), 1'(p % 2), 1'b0, 1'b0, 1'b0, 8'(p * 3));
            @(negedge clk);
            irq_in[p] = 1'b1;
            expect_req(p, 8'h40 + 8'(p), 8'(p * 3), 1'(p % 2), 3'(p % 4), 1'b0,
                       (p == 3) ? 4 : 0, "R2 R3 edge fields");
            expect_none(6, "R3 single delivery per edge");
            irq_in[p] = 1'b0;
            @(negedge clk);
        end

        // R12: line 0 reaches pin 2, pin 0 stays silent
        ent[0] = mk(8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
        @(negedge clk);
        irq_in[0] = 1'b1;
        expect_req(2, 8'h42, 8'd6, 1'b0, 3'd2, 1'b0, 0, "R12 line0 to pin2");
        expect_none(6, "R12 pin0 has no source");
        irq_in[0] = 1'b0;
        @(negedge clk);

        // R5: active-low edge pin triggers on falling raw edge
        irq_in[3] = 1'b1;
        ent[3] = mk(8'h63, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h09);
        expect_none(6, "R5 idle-high line quiet");
        irq_in[3] = 1'b0;
        expect_req(3, 8'h63, 8'h09, 1'b1, 3'd1, 1'b0, 0, "R5 falling edge delivers");
        irq_in[3] = 1'b1;
        expect_none(6, "R5 rising raw edge ignored");

        // R4: masked edge dropped
        ent[4] = mk(8'h64, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h04);
        irq_in[4] = 1'b1;
        repeat (3) @(negedge clk);
        ent[4] = mk(8'h64, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04);
        expect_none(8, "R4 masked edge discarded");
        irq_in[4] = 1'b0;

        // R13: level pin active while masked, delivered after unmask
        do_reset();
        ent[6] = mk(8'h76, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h06);
        irq_in[6] = 1'b1;
        expect_none(6, "R13 masked level held off");
        ent[6] = mk(8'h76, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h06);
        expect_req(6, 8'h76, 8'h06, 1'b0, 3'd0, 1'b1, 0, "R13 unmask delivers");

        // R6 R7 R8: remote-IRR handshake
        do_reset();
        ent[1] = mk(8'h51, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h11);
        irq_in[1] = 1'b1;
        expect_req(1, 8'h51, 8'h11, 1'b0, 3'd0, 1'b1, 0, "R6 level delivers");
        check(remote_irr == 8'h02, "R6 remote set", 64'(remote_irr), 64'h02);
        expect_none(10, "R6 no repeat while remote set");
        eoi(8'h99);
        check(remote_irr == 8'h02, "R7 other vector ignored", 64'(remote_irr), 64'h02);
        expect_none(6, "R7 other vector no redelivery");
        eoi(8'h51);
        check(remote_irr == 8'h00, "R7 matching eoi clears", 64'(remote_irr), 64'h00);
        expect_req(1, 8'h51, 8'h11, 1'b0, 3'd0, 1'b1, 0, "R7 redelivery");
        irq_in[1] = 1'b0;
        repeat (2) @(negedge clk);
        eoi(8'h51);
        check(remote_irr == 8'h00, "R8 eoi clears", 64'(remote_irr), 64'h00);
        expect_none(8, "R8 inactive level not redelivered");

        // R9: simultaneous edges, lowest first
        do_reset();
        for (int p = 3; p < NP; p += 2) ent[p] = mk(8'h80 + 8'(p), 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20);
        @(negedge clk);
        irq_in = 8'b1010_1000;
        expect_req(3, 8'h83, 8'h20, 1'b0, 3'd0, 1'b0, 2, "R9 first lowest");
        expect_req(5, 8'h85, 8'h20, 1'b0, 3'd0, 1'b0, 0, "R9 second");
        expect_req(7, 8'h87, 8'h20, 1'b0, 3'd0, 1'b0, 0, "R9 third");
        irq_in = '0;

        // R10: legacy vector fetch
        do_reset();
        ent[4] = mk(8'h14, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 8'h44);
        @(negedge clk);
        irq_in[4] = 1'b1;
        repeat (4) @(negedge clk);
        check(leg_req && !req_valid, "R10 fetch pending", 64'({leg_req, req_valid}), 64'b10);
        repeat (5) @(negedge clk);
        check(leg_req && !req_valid, "R10 fetch held", 64'({leg_req, req_valid}), 64'b10);
        leg_vector = 8'hA7;
        leg_ack = 1'b1;
        @(negedge clk);
        leg_ack = 1'b0;
        check(!leg_req, "R10 fetch released", 64'(leg_req), 64'd0);
        expect_req(4, 8'hA7, 8'h44, 1'b1, 3'd7, 1'b0, 1, "R10 legacy vector");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule